// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the master side of the two-wire serial management bus used to reach the registers of Ethernet PHYs. It produces the management clock and a data line. The data line is split into an output, an output enable and an input, so the tristate pad stays outside the block. It can run both frame formats on the bus. The short format carries a 5-bit register number. The extended format sends an address frame that carries a 16-bit register address, then a second frame that does the read or write.

A request is presented on a valid/ready handshake. `req_ready` is high only while the master is idle. A request is taken on the rising clock edge where `req_valid` and `req_ready` are both high. Back-pressure therefore lasts for a whole bus transaction, and a requester simply holds its request until it is taken. Completion is reported by a single-cycle `rsp_valid` pulse that carries the read data and an error flag. This response has no ready: the requester must take it in that cycle, and `rsp_rdata` and `rsp_err` keep their values until the next response.

Bus timing is counted in system clocks. `HALF_CYC` sets the low phase of every bit and the high phase of driven bits. `READ_HOLD` sets the longer high phase of released bits, which leaves the PHY time to present data. A parameter selects a board variant in which the data is driven on a separate output pin that idles high, and the shared line is never driven.

Top module: `mdio_master`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in progress. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Request inputs presented while busy have no effect on the frames. `rsp_valid` pulses for one cycle at the end of each transaction.
- R2: Outside a transaction, `mdc` is low and `mdio_oe` is low.
- R3: Every frame starts with 32 driven one bits. A short-format read (`req_op`=00) sends start 01 and opcode 10. A short-format write (`req_op`=01) sends start 01 and opcode 01.
- R4: An extended operation (`req_op[1]`=1) first sends an address frame with start 00, opcode 00 and `req_xaddr` as its 16 data bits. It then sends a frame with start 00, the same port and device fields, and opcode 11 for a read (`req_op`=10) or 01 for a write (`req_op`=11).
- R5: After the opcode come the 5-bit `req_phy` and then the 5-bit `req_regad`, each sent MSB first. Write and address frames continue with a turnaround of 1 then 0 and 16 data bits sent MSB first.
- R6: After the last data bit of a write or address frame, the line is released and one more clock is given, so such a frame has 65 rising edges of `mdc`.
- R7: A read frame drives 46 bits and then releases the line. It clocks one turnaround bit and then 16 data bits, collected MSB first. It ends with one extra released clock, 64 rising edges in all. The collected value is returned in `rsp_rdata` with `rsp_err`=0.
- R8: If the turnaround bit of a read is sampled high, the master clocks 32 further released bits, 79 rising edges in all, and returns `rsp_rdata`=FFFF with `rsp_err`=1.
- R9: The low phase of every bit lasts `HALF_CYC` clocks. The high phase lasts `HALF_CYC` clocks for driven bits and `READ_HOLD` clocks for released bits. Released bits are sampled when `mdc` falls. Driven data changes only while `mdc` is low.
- R10: With `SEP_DOUT`=1, `mdio_oe` stays low, and `mdo_o` carries the data while driving and is high while released. With `SEP_DOUT`=0, `mdo_o` is constantly high.
- R11: A write completes with `rsp_rdata`=0000 and `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request can be taken |
| req_op | input | 2 | bit0: 1 write / 0 read; bit1: 1 extended format |
| req_phy | input | 5 | Port (PHY) address |
| req_regad | input | 5 | Register number, or device address in extended format |
| req_xaddr | input | 16 | Extended register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data (FFFF on error, 0000 for writes) |
| rsp_err | output | 1 | Turnaround not driven low by the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data to the shared line |
| mdio_oe | output | 1 | Drive enable of the shared line |
| mdio_i | input | 1 | Data from the shared line |
| mdo_o | output | 1 | Separate data output pin (high when released) |

## Verification
A PHY model in the bench records every driven bit and counts clock edges. It answers released bits with a chosen turnaround and data word. All four operation codes are issued, so the short and extended start and opcode fields are each seen in both directions. Reads are run with the turnaround low and with it high, which separates the normal 64-edge read from the 79-edge flush and its all-ones error result. Read data such as 8001, all-ones and random words shows bit order and the sampling point. Garbage requests held on the inputs while busy show that back-pressure shields the frame. A second instance in separate-pin mode is compared cycle by cycle against the shared-line instance.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [2:0] {
    FK_C22_RD, FK_C22_WR, FK_C45_AD, FK_C45_RD, FK_C45_WR
  } frame_kind_t;

  localparam int PRE_BITS   = 32;
  localparam int FIELD_W    = 5;
  localparam int DATA_W     = 16;
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * FIELD_W;   // driven bits of a read
  localparam int FRM_BITS   = HDR_BITS + 2 + DATA_W;        // driven bits of a write
  localparam int FLUSH_BITS = 32;
  localparam int WR_TOT     = FRM_BITS + 1;
  localparam int RD_TOT     = HDR_BITS + 1 + DATA_W + 1;
  localparam int RD_BAD_TOT = HDR_BITS + 1 + FLUSH_BITS;
endpackage

// File: rtl/mdio_bit_timer.sv
`timescale 1ns/1ps
module mdio_bit_timer #(
  parameter int HALF_CYC  = 32,
  parameter int READ_HOLD = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rx_bit,
  output logic mdc,
  output logic bit_end
);
  localparam int MAXC = (HALF_CYC > READ_HOLD) ? HALF_CYC : READ_HOLD;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          hi;
  logic [CW-1:0] hi_last, lo_last, ph_last;

  assign hi_last = rx_bit ? CW'(READ_HOLD - 1) : CW'(HALF_CYC - 1);
  assign lo_last = CW'(HALF_CYC - 1);
  assign ph_last = hi ? hi_last : lo_last;
  assign bit_end = run && hi && (cnt == hi_last);
  assign mdc     = hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (cnt == ph_last) begin
      cnt <= '0;
      hi  <= ~hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: once stopped, the clock is low on the next cycle
  a_r2_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R9: the low phase never exceeds its length
  a_r9_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !hi |-> cnt <= lo_last);
endmodule

// File: rtl/mdio_frame_fmt.sv
`timescale 1ns/1ps
module mdio_frame_fmt
  import mdio_pkg::*;
(
  input  frame_kind_t        kind,
  input  logic [FIELD_W-1:0] phy,
  input  logic [FIELD_W-1:0] regad,
  input  logic [DATA_W-1:0]  xaddr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRM_BITS-1:0] frame
);
  logic [1:0]        st, opc;
  logic [DATA_W-1:0] pay;

  always_comb begin
    st  = 2'b00;
    opc = 2'b01;
    pay = wdata;
    case (kind)
      FK_C22_RD: begin st = 2'b01; opc = 2'b10; pay = '0; end
      FK_C22_WR: begin st = 2'b01; opc = 2'b01; end
      FK_C45_AD: begin opc = 2'b00; pay = xaddr; end
      FK_C45_RD: begin opc = 2'b11; pay = '0; end
      default:   opc = 2'b01;
    endcase
  end

  assign frame = {{PRE_BITS{1'b1}}, st, opc, phy, regad, 2'b10, pay};
endmodule

// File: rtl/mdio_pin_drive.sv
`timescale 1ns/1ps
module mdio_pin_drive #(
  parameter bit SEP_DOUT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic dout,
  output logic mdio_o,
  output logic mdio_oe,
  output logic mdo_o
);
  generate
    if (SEP_DOUT) begin : g_sep
      assign mdio_oe = 1'b0;
      assign mdio_o  = 1'b0;
      assign mdo_o   = drive ? dout : 1'b1;
    end else begin : g_shared
      assign mdio_oe = drive;
      assign mdio_o  = dout;
      assign mdo_o   = 1'b1;
    end
  endgenerate

  // R10: a released bus leaves the separate pin high
  a_r10_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> mdo_o);
  // R10: the shared line is only enabled while the sequencer drives
  a_r10_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> drive);
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC  = 32,
  parameter int READ_HOLD = 44,
  parameter bit SEP_DOUT  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_regad,
  input  logic [15:0] req_xaddr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        mdo_o
);
  localparam int IDX_W = $clog2(RD_BAD_TOT + 1);

  logic                busy, drv, c45_pend, op_wr, ta_bad;
  frame_kind_t         kind, start_kind, next_kind, fmt_kind;
  logic [FIELD_W-1:0]  f_phy, f_reg, m_phy, m_reg;
  logic [DATA_W-1:0]   f_xaddr, f_wdata, m_xaddr, m_wdata, rdata;
  logic [FRM_BITS-1:0] sreg, frm;
  logic [IDX_W-1:0]    bit_idx, n_tx, n_tot;
  logic                cur_rd, rx_bit, bit_end, frame_end, dout;
  logic                in_data;

  assign req_ready  = !busy;
  assign start_kind = req_op[1] ? FK_C45_AD : (req_op[0] ? FK_C22_WR : FK_C22_RD);
  assign next_kind  = op_wr ? FK_C45_WR : FK_C45_RD;
  assign fmt_kind   = busy ? next_kind : start_kind;
  assign m_phy      = busy ? f_phy   : req_phy;
  assign m_reg      = busy ? f_reg   : req_regad;
  assign m_xaddr    = busy ? f_xaddr : req_xaddr;
  assign m_wdata    = busy ? f_wdata : req_wdata;

  mdio_frame_fmt u_fmt (
    .kind(fmt_kind), .phy(m_phy), .regad(m_reg),
    .xaddr(m_xaddr), .wdata(m_wdata), .frame(frm)
  );

  assign cur_rd    = (kind == FK_C22_RD) || (kind == FK_C45_RD);
  assign n_tx      = cur_rd ? IDX_W'(HDR_BITS) : IDX_W'(FRM_BITS);
  assign n_tot     = cur_rd ? (ta_bad ? IDX_W'(RD_BAD_TOT) : IDX_W'(RD_TOT))
                            : IDX_W'(WR_TOT);
  assign rx_bit    = busy && (bit_idx >= n_tx);
  assign frame_end = bit_end && (bit_idx == n_tot - IDX_W'(1));
  assign in_data   = cur_rd && !ta_bad && (bit_idx > IDX_W'(HDR_BITS)) &&
                     (bit_idx <= IDX_W'(HDR_BITS + DATA_W));
  assign dout      = sreg[FRM_BITS-1];

  mdio_bit_timer #(.HALF_CYC(HALF_CYC), .READ_HOLD(READ_HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .rx_bit(rx_bit),
    .mdc(mdc), .bit_end(bit_end)
  );

  mdio_pin_drive #(.SEP_DOUT(SEP_DOUT)) u_pins (
    .clk(clk), .rst_n(rst_n), .drive(drv), .dout(dout),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdo_o(mdo_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      drv       <= 1'b0;
      c45_pend  <= 1'b0;
      op_wr     <= 1'b0;
      ta_bad    <= 1'b0;
      kind      <= FK_C22_RD;
      f_phy     <= '0;
      f_reg     <= '0;
      f_xaddr   <= '0;
      f_wdata   <= '0;
      sreg      <= '0;
      bit_idx   <= '0;
      rdata     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy     <= 1'b1;
          drv      <= 1'b1;
          c45_pend <= req_op[1];
          op_wr    <= req_op[0];
          kind     <= start_kind;
          f_phy    <= req_phy;
          f_reg    <= req_regad;
          f_xaddr  <= req_xaddr;
          f_wdata  <= req_wdata;
          sreg     <= frm;
          bit_idx  <= '0;
          ta_bad   <= 1'b0;
          rdata    <= '0;
        end
      end else if (bit_end) begin
        if (cur_rd && (bit_idx == IDX_W'(HDR_BITS)) && mdio_i)
          ta_bad <= 1'b1;
        if (in_data)
          rdata <= {rdata[DATA_W-2:0], mdio_i};
        if (frame_end) begin
          if (c45_pend) begin
            c45_pend <= 1'b0;
            kind     <= next_kind;
            sreg     <= frm;
            bit_idx  <= '0;
            ta_bad   <= 1'b0;
            drv      <= 1'b1;
          end else begin
            busy      <= 1'b0;
            drv       <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= ta_bad;
            rsp_rdata <= !cur_rd ? '0 : (ta_bad ? '1 : rdata);
          end
        end else begin
          bit_idx <= bit_idx + IDX_W'(1);
          sreg    <= {sreg[FRM_BITS-2:0], 1'b0};
          drv     <= (bit_idx + IDX_W'(1)) < n_tx;
        end
      end
    end
  end

  // R2: idle bus is quiet
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mdc && !drv));
  // R9: driven data only moves while the clock is low
  a_r9_data_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> !mdc);
  // R1: completion is a single-cycle pulse
  a_r1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R1: latched request fields hold for the whole transaction
  a_r1_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(f_phy) && $stable(f_reg) && $stable(f_wdata)));
  // R8: an error response carries all ones
  a_r8_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 16'hFFFF));
  // R6: the line is only driven inside a transaction
  a_r6_drive_busy: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> busy);
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int HALF = 3;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [4:0]  req_phy = '0, req_regad = '0;
  logic [15:0] req_xaddr = '0, req_wdata = '0;
  logic        mdio_i = 1'b1;
  wire         req_ready, rsp_valid, rsp_err, mdc, mdio_o, mdio_oe, mdo_o;
  wire  [15:0] rsp_rdata;
  wire         s_ready, s_valid, s_err, s_mdc, s_mdio_o, s_mdio_oe, s_mdo;
  wire  [15:0] s_rdata;

  mdio_master #(.HALF_CYC(HALF), .READ_HOLD(HOLD), .SEP_DOUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_phy(req_phy), .req_regad(req_regad),
    .req_xaddr(req_xaddr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .mdo_o(mdo_o));

  mdio_master #(.HALF_CYC(HALF), .READ_HOLD(HOLD), .SEP_DOUT(1'b1)) uut_sep (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(s_ready),
    .req_op(req_op), .req_phy(req_phy), .req_regad(req_regad),
    .req_xaddr(req_xaddr), .req_wdata(req_wdata), .rsp_valid(s_valid),
    .rsp_rdata(s_rdata), .rsp_err(s_err), .mdc(s_mdc), .mdio_o(s_mdio_o),
    .mdio_oe(s_mdio_oe), .mdio_i(mdio_i), .mdo_o(s_mdo));

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // PHY model and bus monitors
  logic         ta_bit = 1'b0;
  logic [15:0]  rd_val = '0;
  logic [127:0] cap = '0;
  int           ncap = 0, rises = 0, rx_k = 0;
  int           hi_cnt = 0, lo_cnt = 0, tim_err = 0, sep_err = 0;
  bit           lo_ok = 1'b0, hi_rx = 1'b0;
  logic         prev_mdc = 1'b0, prev_ready = 1'b1, prev_oe = 1'b0, prev_o = 1'b0;

  function automatic logic phy_bit(input int k);
    if (k == 0) return ta_bit;
    if (k <= 16) return rd_val[16-k];
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ready && !req_ready) begin
        cap = '0; ncap = 0; rises = 0; rx_k = 0; lo_ok = 1'b0; mdio_i = 1'b1;
      end
      if (mdc && !prev_mdc) begin
        rises++;
        if (lo_ok && lo_cnt != HALF) tim_err++;
        hi_cnt = 0;
        hi_rx  = !mdio_oe;
        if (mdio_oe) begin
          cap = {cap[126:0], mdio_o};
          ncap++;
          rx_k = 0;
        end else begin
          mdio_i = phy_bit(rx_k);
          rx_k++;
        end
      end
      if (!mdc && prev_mdc) begin
        if (hi_cnt != (hi_rx ? HOLD : HALF)) tim_err++;
        lo_ok  = 1'b1;
        lo_cnt = 0;
      end
      if (mdc) hi_cnt++; else lo_cnt++;
      if (req_ready) lo_ok = 1'b0;
      if (mdc && prev_oe && mdio_oe && (mdio_o != prev_o)) tim_err++;
      if (s_mdio_oe !== 1'b0 || s_mdo !== (mdio_oe ? mdio_o : 1'b1) || s_mdc !== mdc)
        sep_err++;
      if (mdo_o !== 1'b1) sep_err++;
      prev_mdc   = mdc;
      prev_ready = req_ready;
      prev_oe    = mdio_oe;
      prev_o     = mdio_o;
    end
  end

  function automatic logic [63:0] frm(input logic [1:0] st, input logic [1:0] opc,
                                      input logic [4:0] p, input logic [4:0] r,
                                      input logic [15:0] d);
    return {32'hFFFF_FFFF, st, opc, p, r, 2'b10, d};
  endfunction

  task automatic run_txn(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] a, input logic [15:0] w,
                         input logic ta1, input logic [15:0] rv, input bit junk);
    logic [127:0] exp_cap;
    int exp_n, exp_rises, t0, s0;
    logic [15:0] exp_rd;
    logic exp_err;
    logic [63:0] fa, fb;
    string ftag;
    ta_bit = ta1; rd_val = rv; t0 = tim_err; s0 = sep_err;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_phy = p; req_regad = r;
    req_xaddr = a; req_wdata = w;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (junk) begin
      req_op = ~op; req_phy = ~p; req_regad = ~r; req_xaddr = ~a; req_wdata = ~w;
      for (int i = 0; i < 20; i++) begin
        chk(!req_ready, "R1 ready low while busy", {127'b0, req_ready}, 128'd0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    // expected values from the frame rules
    fb = '0;
    case (op)
      2'b00: begin fa = frm(2'b01, 2'b10, p, r, 16'h0);
             exp_cap = {64'b0, fa >> 18}; exp_n = 46;
             exp_rises = ta1 ? 79 : 64; ftag = "R3 R5 frame bits"; end
      2'b01: begin fa = frm(2'b01, 2'b01, p, r, w);
             exp_cap = {64'b0, fa}; exp_n = 64; exp_rises = 65;
             ftag = "R3 R5 frame bits"; end
      2'b10: begin fa = frm(2'b00, 2'b00, p, r, a); fb = frm(2'b00, 2'b11, p, r, 16'h0);
             exp_cap = ({64'b0, fa} << 46) | {64'b0, fb >> 18}; exp_n = 110;
             exp_rises = 65 + (ta1 ? 79 : 64); ftag = "R4 R5 frame bits"; end
      default: begin fa = frm(2'b00, 2'b00, p, r, a); fb = frm(2'b00, 2'b01, p, r, w);
             exp_cap = {fa, fb}; exp_n = 128; exp_rises = 130;
             ftag = "R4 R5 frame bits"; end
    endcase
    if (op[0]) begin exp_rd = 16'h0000; exp_err = 1'b0; end
    else if (ta1) begin exp_rd = 16'hFFFF; exp_err = 1'b1; end
    else begin exp_rd = rv; exp_err = 1'b0; end

    chk(cap == exp_cap, ftag, cap, exp_cap);
    chk(ncap == exp_n, "R3 R7 driven bit count", 128'(ncap), 128'(exp_n));
    chk(rises == exp_rises, op[0] ? "R6 clock edges" : (ta1 ? "R8 clock edges" : "R7 clock edges"),
        128'(rises), 128'(exp_rises));
    chk(rsp_rdata == exp_rd, op[0] ? "R11 write rdata" : (ta1 ? "R8 error rdata" : "R7 read data"),
        128'(rsp_rdata), 128'(exp_rd));
    chk(rsp_err == exp_err, ta1 && !op[0] ? "R8 error flag" : "R7 R11 error flag",
        128'(rsp_err), 128'(exp_err));
    chk(!mdc && !mdio_oe && req_ready, "R2 idle after done",
        {125'b0, mdc, mdio_oe, req_ready}, 128'd1);
    chk(tim_err == t0, "R9 bit timing", 128'(tim_err - t0), 128'd0);
    chk(sep_err == s0, "R10 separate pin", 128'(sep_err - s0), 128'd0);
    @(negedge clk);
    chk(!rsp_valid, "R1 single pulse", {127'b0, rsp_valid}, 128'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mdc && !mdio_oe && !rsp_valid && mdo_o,
        "R2 reset state", {123'b0, req_ready, mdc, mdio_oe, rsp_valid, mdo_o}, 128'h11);
    // directed corners
    run_txn(2'b00, 5'h01, 5'h02, 16'h0, 16'h0, 1'b0, 16'h8001, 1'b1);
    run_txn(2'b01, 5'h1F, 5'h00, 16'h0, 16'hFFFF, 1'b0, 16'h0, 1'b0);
    run_txn(2'b01, 5'h00, 5'h1F, 16'h0, 16'h0000, 1'b0, 16'h0, 1'b1);
    run_txn(2'b00, 5'h15, 5'h0A, 16'h0, 16'h0, 1'b1, 16'h1234, 1'b0);
    run_txn(2'b10, 5'h03, 5'h1E, 16'hA55A, 16'h0, 1'b0, 16'hFFFF, 1'b0);
    run_txn(2'b10, 5'h07, 5'h01, 16'h0001, 16'h0, 1'b1, 16'h0000, 1'b1);
    run_txn(2'b11, 5'h10, 5'h05, 16'h8000, 16'h7FFE, 1'b0, 16'h0, 1'b1);
    // random traffic
    for (int n = 0; n < 30; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      run_txn(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
              (!op[0]) && ($urandom_range(0, 4) == 0), 16'($urandom),
              $urandom_range(0, 3) == 0);
    end
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule